// File: doc/BRIEF.md
# Condition Code Evaluator with Set-Byte Merge

This block judges a 3-bit condition code against the current overflow, sign and zero flags and turns the verdict into one of two actions. For a conditional-jump operation it raises a taken output. For a set-byte operation it writes 1 or 0 into the least significant byte of a 64-bit destination value and keeps the upper 56 bits. It produces the merged word together with a write-enable. The flags come from a flag register outside the block. The block never changes the flags. Branch-target handling is also left to the surrounding pipeline.

The signed orderings come from comparing the sign flag with the overflow flag. No carry flag is involved. Every result is registered, so each answer appears on the outputs one clock after the operation is presented. The reset is synchronous and active low.

Top module: `cc_eval_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next values of `taken_o`, `wr_en_o` and `wr_data_o` are all zero, whatever the other inputs are.
- R2: Code 0 (equal) holds exactly when the zero flag is 1. Code 1 (not equal) holds exactly when the zero flag is 0.
- R3: Code 2 (signed less-than) holds exactly when the sign flag differs from the overflow flag.
- R4: Code 3 (less-or-equal) holds when less-than holds or the zero flag is 1. Code 4 (greater-than) holds exactly when less-or-equal does not.
- R5: Code 5 (greater-or-equal) holds exactly when the sign flag equals the overflow flag.
- R6: Codes 6 and 7 are reserved and always evaluate false, for every flag combination.
- R7: Operation select 1 (jump) sets `taken_o` to the condition result one cycle later and keeps `wr_en_o` at 0 and `wr_data_o` at zero.
- R8: Operation select 2 (set-byte) drives `wr_en_o` to 1 one cycle later. `wr_data_o[7:0]` is 8'h01 if the condition holds and 8'h00 otherwise. `wr_data_o[63:8]` equals `dest_i[63:8]` as presented, and `taken_o` is 0.
- R9: Operation select 0 (idle) and the reserved select 3 have no effect. One cycle later `taken_o` and `wr_en_o` are 0 and `wr_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| flag_ovf_i | input | 1 | Overflow flag from the flag register |
| flag_sgn_i | input | 1 | Sign flag from the flag register |
| flag_zero_i | input | 1 | Zero flag from the flag register |
| cond_i | input | 3 | Condition code: 0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge, 6/7 reserved |
| op_i | input | 2 | Operation: 0 idle, 1 jump, 2 set-byte, 3 reserved (idle) |
| dest_i | input | 64 | Current destination value for set-byte |
| taken_o | output | 1 | Conditional jump taken, registered |
| wr_en_o | output | 1 | Write-enable for the merged destination, registered |
| wr_data_o | output | 64 | Destination with the low byte replaced, registered |

## Verification
All three outputs come from one rank of registers. A result is therefore due exactly one rising edge after its operation, flags, code and destination are presented. The bench drives each vector on a falling edge and reads the outputs on the next falling edge, which falls half a period after the edge that captured the vector. It then applies the next vector on that same falling edge. The sweep covers every code, every flag combination and every operation select, with a different destination word on each vector. Every output of every vector is compared against a value the bench computes on its own.

// File: rtl/cc_eval_pkg.sv
// Package: shared encodings for the condition evaluator.
// Assumes: the condition code is 3 bits wide and the operation select is 2 bits wide.
package cc_eval_pkg;

    localparam int CC_W = 3;
    localparam int OP_W = 2;

    typedef enum logic [CC_W-1:0] {
        CC_EQ   = 3'd0,
        CC_NE   = 3'd1,
        CC_LT   = 3'd2,
        CC_LE   = 3'd3,
        CC_GT   = 3'd4,
        CC_GE   = 3'd5,
        CC_RSV6 = 3'd6,
        CC_RSV7 = 3'd7
    } cc_code_e;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE = 2'd0,
        OP_JUMP = 2'd1,
        OP_SETB = 2'd2,
        OP_RSV  = 2'd3
    } cc_op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zero;
    } cc_flags_t;

endpackage

// File: rtl/cc_cond_decode.sv
// Module: cc_cond_decode
// Evaluates a condition code against the three flags, purely combinationally.
// Assumes: the flags are stable for the whole cycle. Reserved codes give false.
module cc_cond_decode
    import cc_eval_pkg::*;
(
    input  cc_flags_t             flags_i,
    input  logic [CC_W-1:0]       code_i,
    output logic                  hold_o
);

    logic less_w;
    logic less_eq_w;

    // Signed ordering terms, built from sign versus overflow
    always_comb begin
        less_w    = flags_i.sgn ^ flags_i.ovf;
        less_eq_w = less_w | flags_i.zero;
    end

    // Select the verdict for the presented code
    always_comb begin
        case (cc_code_e'(code_i))
            CC_EQ:   hold_o = flags_i.zero;
            CC_NE:   hold_o = ~flags_i.zero;
            CC_LT:   hold_o = less_w;
            CC_LE:   hold_o = less_eq_w;
            CC_GT:   hold_o = ~less_eq_w;
            CC_GE:   hold_o = ~less_w;
            default: hold_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cc_lane_merge.sv
// Module: cc_lane_merge
// Replaces the lowest lane of a word with a zero-extended single bit and keeps every other lane.
// Assumes: DATA_W is a whole multiple of LANE_W.
module cc_lane_merge #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] merged_o
);

    localparam int N_LANES = DATA_W / LANE_W;

    // Lane 0 takes the bit and the others pass through unchanged
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign merged_o[LANE_W-1:0] = {{(LANE_W-1){1'b0}}, bit_i};
        end else begin : g_keep
            assign merged_o[g*LANE_W +: LANE_W] = word_i[g*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/cc_eval_unit.sv
// Module: cc_eval_unit (top)
// Registers the condition verdict as a jump-taken flag, or as a set-byte write of the destination.
// Assumes: the flags come from a register upstream. The reset is synchronous and active low.
// Results appear one cycle after the operation is presented.
module cc_eval_unit
    import cc_eval_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_ovf_i,
    input  logic              flag_sgn_i,
    input  logic              flag_zero_i,
    input  logic [2:0]        cond_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] dest_i,
    output logic              taken_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o
);

    cc_flags_t         flags_w;
    logic              hold_w;
    logic [DATA_W-1:0] merged_w;

    // Gather the loose flag pins into the shared struct
    always_comb flags_w = '{ovf: flag_ovf_i, sgn: flag_sgn_i, zero: flag_zero_i};

    cc_cond_decode u_decode (
        .flags_i (flags_w),
        .code_i  (cond_i),
        .hold_o  (hold_w)
    );

    cc_lane_merge #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_merge (
        .word_i   (dest_i),
        .bit_i    (hold_w),
        .merged_o (merged_w)
    );

    // Output register: the operation select chooses which result is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            case (cc_op_e'(op_i))
                OP_JUMP: begin
                    taken_o   <= hold_w;
                    wr_en_o   <= 1'b0;
                    wr_data_o <= '0;
                end
                OP_SETB: begin
                    taken_o   <= 1'b0;
                    wr_en_o   <= 1'b1;
                    wr_data_o <= merged_w;
                end
                default: begin
                    taken_o   <= 1'b0;
                    wr_en_o   <= 1'b0;
                    wr_data_o <= '0;
                end
            endcase
        end
    end

    // R7: a jump never comes with a write
    p_jump_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> !wr_en_o);

    // R8: the upper lanes follow the destination that was presented
    p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'd2) |-> (wr_en_o &&
            wr_data_o[DATA_W-1:LANE_W] == $past(dest_i[DATA_W-1:LANE_W])));

    // R8: the written byte is only ever 0 or 1
    p_low_byte_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_data_o[LANE_W-1:1] == '0));

    // R6: a reserved code never takes a jump
    p_reserved_false_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'd1 && $past(cond_i) >= 3'd6) |-> !taken_o);

    // R9: idle or reserved selects leave every output quiet
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == 2'd0 || $past(op_i) == 2'd3))
            |-> (!taken_o && !wr_en_o && wr_data_o == '0));

endmodule

// File: tb/cc_eval_unit_bench.sv
// Bench: sweeps every code, flag combination and operation select, with varied destination words.
module cc_eval_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        f_ovf = 1'b0, f_sgn = 1'b0, f_zero = 1'b0;
    logic [2:0]  cond = '0;
    logic [1:0]  op = '0;
    logic [63:0] dest = '0;
    logic        taken;
    logic        wr_en;
    logic [63:0] wr_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    cc_eval_unit u_cc_eval_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_ovf_i  (f_ovf),
        .flag_sgn_i  (f_sgn),
        .flag_zero_i (f_zero),
        .cond_i      (cond),
        .op_i        (op),
        .dest_i      (dest),
        .taken_o     (taken),
        .wr_en_o     (wr_en),
        .wr_data_o   (wr_data)
    );

    // Expected verdict, worked out by counting the flags rather than by gates
    function automatic bit expect_cond(input int c, input bit o, input bit s, input bit z);
        bit lt;
        lt = ((int'(s) + int'(o)) == 1);
        case (c)
            0: return z;
            1: return z == 1'b0;
            2: return lt;
            3: return lt || z;
            4: return !(lt || z);
            5: return !lt;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string cond_tag(input int c);
        case (c)
            0, 1: return "R2";
            2: return "R3";
            3, 4: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset clears every output even while a set-byte is requested
        @(negedge clk);
        op = 2'd2; cond = 3'd1; dest = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        check("R1", "taken in reset", {63'd0, taken}, 64'd0);
        check("R1", "wr_en in reset", {63'd0, wr_en}, 64'd0);
        check("R1", "wr_data in reset", wr_data, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 256; i++) begin
            int  c;
            int  o_sel;
            bit  fo, fs, fz, v;
            logic [63:0] d;
            c = i % 8;
            fo = i[3]; fs = i[4]; fz = i[5];
            o_sel = (i >> 6) & 3;
            d = (64'(i) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
            f_ovf = fo; f_sgn = fs; f_zero = fz;
            cond = 3'(c); op = 2'(o_sel); dest = d;
            v = expect_cond(c, fo, fs, fz);
            @(negedge clk);
            case (o_sel)
                1: begin
                    check(cond_tag(c), "jump taken", {63'd0, taken}, {63'd0, v});
                    check("R7", "jump wr_en", {63'd0, wr_en}, 64'd0);
                    check("R7", "jump wr_data", wr_data, 64'd0);
                end
                2: begin
                    check(cond_tag(c), "setb data", wr_data, {d[63:8], 7'd0, v});
                    check("R8", "setb wr_en", {63'd0, wr_en}, 64'd1);
                    check("R8", "setb taken", {63'd0, taken}, 64'd0);
                end
                default: begin
                    check("R9", "idle taken", {63'd0, taken}, 64'd0);
                    check("R9", "idle wr_en", {63'd0, wr_en}, 64'd0);
                    check("R9", "idle wr_data", wr_data, 64'd0);
                end
            endcase
        end

        // R1: a reset after activity clears the outputs again
        op = 2'd2; cond = 3'd0; f_zero = 1'b1; dest = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        check("R8", "setb before reset", wr_data, 64'h1234_5678_9ABC_DE01);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "wr_data after reset", wr_data, 64'd0);
        check("R1", "wr_en after reset", {63'd0, wr_en}, 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule